// File: doc/BRIEF.md
# Two-Bus General Register Datapath

This block is the execute core of a small processor: seven general-purpose registers, two operand buses and one shared ALU. Every clock cycle a four-field control word picks the source of bus A, the source of bus B, the ALU operation and the destination register. Each bus can carry one of the seven registers or an external input word.

The ALU result leaves the block on a combinational output. It is also presented to all seven register inputs, and the destination decoder enables at most one of them. The carry and zero flags of the operation are captured on every edge, whether or not a register is written. Fetch, sequencing and memory sit outside the block and supply the control word, which must be valid by the start of the cycle.

Top module: `gpr_datapath`

## Requirements
- R1: An active-low asynchronous reset clears all seven registers, the carry flag and the zero flag to zero.
- R2: Source select code 0 places `ext_data_i` on the bus. Codes 1 to 7 place register Rn on the bus. This holds for both the A bus and the B bus.
- R3: The arithmetic operation codes, with carry as the unsigned carry out of bit 7, are:
  - 0 transfers A, with carry 0.
  - 1 computes A+1.
  - 2 computes A+B.
  - 3 computes A+~B+1, so carry is 1 when A>=B.
  - 6 computes A+0xFF, so carry is 1 when A!=0.
- R4: The logic operation codes give carry 0: 8 is A AND B, 10 is A OR B, 12 is A XOR B, and 14 is NOT A.
- R5: Operation code 16 shifts A right, shifting in 0, and carry takes A[0]. Code 24 shifts A left, shifting in 0, and carry takes A[7].
- R6: Destination code n (1 to 7) writes the ALU result into Rn at the clock edge and leaves every other register unchanged. At most one load enable is active.
- R7: Destination code 0 writes no register.
- R8: The carry and zero flags are registered on every clock edge for whatever operation is presented, independent of the destination code. Zero is 1 when the result is 0x00.
- R9: When the same register is both a source and the destination, the operation uses its old value, and the new value appears only after the edge.
- R10: Any operation code not listed gives result 0x00 with carry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_a_i | input | 3 | A bus source select |
| sel_b_i | input | 3 | B bus source select |
| opr_i | input | 5 | ALU operation code |
| sel_d_i | input | 3 | Destination register select, 0 means none |
| ext_data_i | input | 8 | External input word |
| result_o | output | 8 | Combinational ALU result |
| carry_o | output | 1 | Registered carry flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
Within one cycle, a register can be read as a source and written as the destination. Flag capture and a register load also share the same edge, even when the destination code is zero. The bench provokes the first case with transfers such as R4 <- R4 + R4 and R5 <- R5 - 1. It judges them by comparing the combinational result against a model that still holds the old value, then reads the register back on a later cycle. For the second case, the model updates the flags on every edge and updates register contents only for non-zero destination codes. A long randomised run then mixes all codes, so the bench compares the result every cycle and the flags after every edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_TRA = 5'd0,
    OP_INC = 5'd1,
    OP_ADD = 5'd2,
    OP_SUB = 5'd3,
    OP_DEC = 5'd6,
    OP_AND = 5'd8,
    OP_OR  = 5'd10,
    OP_XOR = 5'd12,
    OP_COM = 5'd14,
    OP_SHR = 5'd16,
    OP_SHL = 5'd24
  } alu_op_e;
endpackage

// File: rtl/gpr_regfile.sv
module gpr_regfile #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 7,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [SEL_W-1:0]                 sel_d_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  logic [NUM_REGS-1:0]             load_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  // destination decoder: code 0 selects nothing
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign load_en[g] = (sel_d_i == SEL_W'(g + 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         regs_q[g] <= '0;
      else if (load_en[g]) regs_q[g] <= wdata_i;
    end
  end

  assign regs_o = regs_q;

  p_onehot_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_en));

  p_dest_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_d_i != '0) |=> regs_q[$past(sel_d_i) - 1'b1] == $past(wdata_i));

  p_no_dest_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_d_i == '0) |=> $stable(regs_q));
endmodule

// File: rtl/gpr_bus_mux.sv
module gpr_bus_mux #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 7,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS + 1)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [DATA_W-1:0]               ext_i,
  input  logic [SEL_W-1:0]                sel_i,
  output logic [DATA_W-1:0]               bus_o
);
  always_comb begin
    bus_o = ext_i;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel_i == SEL_W'(i + 1)) bus_o = regs_i[i];
    end
  end
endmodule

// File: rtl/gpr_alu.sv
module gpr_alu
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic [DATA_W:0] sum;

  always_comb begin
    sum = '0;
    unique case (op_i)
      OP_TRA: sum = {1'b0, a_i};
      OP_INC: sum = {1'b0, a_i} + (DATA_W+1)'(1);
      OP_ADD: sum = {1'b0, a_i} + {1'b0, b_i};
      OP_SUB: sum = {1'b0, a_i} + {1'b0, ~b_i} + (DATA_W+1)'(1);
      OP_DEC: sum = {1'b0, a_i} + {1'b0, {DATA_W{1'b1}}};
      OP_AND: sum = {1'b0, a_i & b_i};
      OP_OR:  sum = {1'b0, a_i | b_i};
      OP_XOR: sum = {1'b0, a_i ^ b_i};
      OP_COM: sum = {1'b0, ~a_i};
      OP_SHR: sum = {a_i[0], 1'b0, a_i[DATA_W-1:1]};
      OP_SHL: sum = {a_i, 1'b0};
      default: sum = '0;
    endcase
  end

  assign res_o   = sum[DATA_W-1:0];
  assign carry_o = sum[DATA_W];

  p_shl_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHL) |-> (carry_o == a_i[DATA_W-1]) && (res_o[0] == 1'b0));

  p_logic_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i inside {OP_AND, OP_OR, OP_XOR, OP_COM}) |-> !carry_o);
endmodule

// File: rtl/gpr_datapath.sv
module gpr_datapath
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 7,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_a_i,
  input  logic [SEL_W-1:0]  sel_b_i,
  input  logic [OP_W-1:0]   opr_i,
  input  logic [SEL_W-1:0]  sel_d_i,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]               bus_a, bus_b, alu_res;
  logic                            alu_carry, carry_q, zero_q;

  gpr_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_d_i(sel_d_i),
    .wdata_i(alu_res),
    .regs_o (regs)
  );

  gpr_bus_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_mux_a (
    .regs_i(regs), .ext_i(ext_data_i), .sel_i(sel_a_i), .bus_o(bus_a)
  );

  gpr_bus_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_mux_b (
    .regs_i(regs), .ext_i(ext_data_i), .sel_i(sel_b_i), .bus_o(bus_b)
  );

  gpr_alu #(.DATA_W(DATA_W)) u_alu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (opr_i),
    .a_i    (bus_a),
    .b_i    (bus_b),
    .res_o  (alu_res),
    .carry_o(alu_carry)
  );

  // flags follow every operation, written or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      carry_q <= alu_carry;
      zero_q  <= (alu_res == '0);
    end
  end

  assign result_o = alu_res;
  assign carry_o  = carry_q;
  assign zero_o   = zero_q;

  p_ext_on_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opr_i == OP_TRA && sel_a_i == '0) |-> result_o == ext_data_i);

  p_zero_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> zero_o == ($past(result_o) == '0));
endmodule

// File: tb/gpr_datapath_tb.sv
module gpr_datapath_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_a_i = '0, sel_b_i = '0, sel_d_i = '0;
  logic [4:0] opr_i = '0;
  logic [7:0] ext_data_i = '0;
  logic [7:0] result_o;
  logic       carry_o, zero_o;

  int checks = 0;
  int errors = 0;
  int model[1:7];
  int m_c = 0, m_z = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpr_datapath dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
    .opr_i(opr_i), .sel_d_i(sel_d_i), .ext_data_i(ext_data_i),
    .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
  );

  function automatic void ref_alu(input int op, input int a, input int b,
                                  output int r, output int c);
    int s;
    s = 0; c = 0;
    case (op)
      0:  s = a;
      1:  s = a + 1;
      2:  s = a + b;
      3:  s = a + (255 - b) + 1;
      6:  s = a + 255;
      8:  s = a & b;
      10: s = a | b;
      12: s = a ^ b;
      14: s = 255 - a;
      16: begin s = a >> 1; c = a & 1; end
      24: begin s = a << 1; c = (a >> 7) & 1; end
      default: s = 0;
    endcase
    if (op != 16 && op != 24) c = (s >> 8) & 1;
    r = s & 255;
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0, 1, 2, 3, 6:  return "R3";
      8, 10, 12, 14:  return "R4";
      16, 24:         return "R5";
      default:        return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int src(input int sel, input int ext);
    return (sel == 0) ? ext : model[sel];
  endfunction

  // one cycle: drive, check result, clock, update model, check flags
  task automatic step(input int sa, input int sb, input int op, input int sd,
                      input int ext, input string tag);
    int r, c;
    @(negedge clk_i);
    sel_a_i = 3'(sa); sel_b_i = 3'(sb); opr_i = 5'(op);
    sel_d_i = 3'(sd); ext_data_i = 8'(ext);
    ref_alu(op, src(sa, ext), src(sb, ext), r, c);
    #2;
    check(tag, "result", int'(result_o), r);
    @(posedge clk_i);
    if (sd != 0) model[sd] = r;
    m_c = c; m_z = (r == 0) ? 1 : 0;
    #1;
    check("R8", "carry", int'(carry_o), m_c);
    check("R8", "zero", int'(zero_o), m_z);
  endtask

  task automatic readback(input int n, input string tag);
    int r, c;
    @(negedge clk_i);
    sel_a_i = 3'(n); sel_b_i = '0; opr_i = '0; sel_d_i = '0; ext_data_i = '0;
    ref_alu(0, model[n], 0, r, c);
    #2;
    check(tag, $sformatf("R%0d readback", n), int'(result_o), r);
    @(posedge clk_i);
    m_c = 0; m_z = (r == 0) ? 1 : 0;
  endtask

  task automatic readback_all(input string tag);
    for (int n = 1; n <= 7; n++) readback(n, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ops[12] = '{0, 1, 2, 3, 6, 8, 10, 12, 14, 16, 24, 5};
    for (int n = 1; n <= 7; n++) model[n] = 0;
    #23;
    check("R1", "carry after reset", int'(carry_o), 0);
    check("R1", "zero after reset", int'(zero_o), 0);
    rst_ni = 1'b1;
    readback_all("R1");

    // R2, R6: load each register from the external word
    for (int n = 1; n <= 7; n++) step(0, 0, 0, n, 8'h11 * n, "R2");
    readback_all("R6");

    // R3: arithmetic, with boundary carries
    step(2, 3, 2, 1, 0, "R3");        // R1 <- R2 + R3
    step(0, 7, 2, 0, 8'hF0, "R3");    // ext + R7 overflow
    step(0, 0, 1, 6, 8'hFF, "R3");    // inc wraps to zero
    step(6, 0, 6, 0, 0, "R3");        // dec of zero
    step(3, 3, 3, 0, 0, "R3");        // A == B subtract
    step(2, 3, 3, 2, 0, "R3");        // A < B subtract

    // R4 / R5 / R10
    step(4, 5, 8, 0, 0, "R4");
    step(4, 5, 10, 0, 0, "R4");
    step(4, 4, 12, 0, 0, "R4");
    step(0, 0, 14, 3, 8'h5A, "R4");
    step(0, 0, 16, 0, 8'h81, "R5");
    step(0, 0, 24, 0, 8'h81, "R5");
    step(0, 0, 24, 0, 8'h40, "R5");
    step(7, 1, 5, 5, 0, "R10");
    step(7, 1, 31, 0, 0, "R10");

    // R7: no destination, registers keep their values
    step(0, 0, 0, 0, 8'hAA, "R7");
    step(1, 2, 2, 0, 0, "R7");
    readback_all("R7");

    // R9: same register read and written in one cycle
    step(4, 4, 2, 4, 0, "R9");
    step(5, 0, 6, 5, 0, "R9");
    readback(4, "R9");
    readback(5, "R9");

    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 7), $urandom_range(0, 7), ops[$urandom_range(0, 11)],
           $urandom_range(0, 7), $urandom_range(0, 255), "R6");
    readback_all("R6");

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    for (int n = 1; n <= 7; n++) model[n] = 0;
    check("R1", "carry in reset", int'(carry_o), 0);
    check("R1", "zero in reset", int'(zero_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    readback_all("R1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule